// File: doc/BRIEF.md
# Configurable True Dual-Port RAM

A synchronous word memory with two fully independent read/write ports, A and B, sharing one storage array that is clocked on `clk0`. Each port carries its own address, write data, write strobe, per-lane byte enables, an input clock enable, an output clock enable, and a read-data bus. Both ports use the same word width and depth. Writes are masked lane by lane, and the lane size can be 5, 8, 9 or 10 bits.

Each port has its own read path, chosen by parameter. In unregistered mode the port shows the read holding register directly, one `clk0` edge after the request. In registered mode an extra output register follows the holding register, clocked on either `clk0` or `clk1`. Each port can enable an asynchronous clear and a synchronous clear on its own. In registered mode the clears act on the output register. In unregistered mode they act on the holding register. Either clock enable can be honoured or bypassed, and a bypassed enable is treated as always high.

Top module: `tdp_ram`

## Requirements
- R1: The byte-enable bus of each port is DATA_W/BYTE_SZ bits wide. Bit i governs data bits [i*BYTE_SZ +: BYTE_SZ]. BYTE_SZ must be 5, 8, 9 or 10 and must divide DATA_W exactly, or elaboration stops with an error.
- R2: A lane of the addressed word is written at a `clk0` rising edge only when the effective input enable, the write strobe and that lane's byte-enable bit are all 1. All other lanes keep their stored contents.
- R3: A read is captured at a `clk0` edge with the effective input enable high. An unregistered port presents it after that edge. A registered port presents it after the next rising edge of its selected output clock, which is two edges when that clock runs with `clk0`.
- R4: When a port reads the address it is writing, it returns the new data in the lanes it writes and the previously stored data in its masked lanes.
- R5: When both ports write the same address in the same cycle, port A's data is stored in every lane that port A writes. Port B's data is stored only in the lanes that A leaves masked.
- R6: With the input enable honoured and held low, a port neither writes nor captures a read, so its output holds. With the input enable bypassed, its level has no effect.
- R7: With the output enable honoured and held low, a registered port's output holds its value.
- R8: While an enabled asynchronous clear is high, the port output is zero at once, with no clock edge needed. On a port whose asynchronous clear is disabled, the clear input has no effect.
- R9: An enabled synchronous clear sets the port output to zero at the next edge and overrides the output enable. On an unregistered port it clears the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Array, input-stage and holding-register clock |
| clk1 | input | 1 | Alternative output-register clock |
| aclrA | input | 1 | Port A asynchronous output clear |
| sclrA | input | 1 | Port A synchronous output clear |
| addrA | input | ADDR_W | Port A word address |
| wrDataA | input | DATA_W | Port A write data |
| wrEnA | input | 1 | Port A write strobe |
| byteEnA | input | DATA_W/BYTE_SZ | Port A lane write mask |
| inClkEnA | input | 1 | Port A input-stage enable |
| outClkEnA | input | 1 | Port A output-register enable |
| rdDataA | output | DATA_W | Port A read data |
| aclrB | input | 1 | Port B asynchronous output clear |
| sclrB | input | 1 | Port B synchronous output clear |
| addrB | input | ADDR_W | Port B word address |
| wrDataB | input | DATA_W | Port B write data |
| wrEnB | input | 1 | Port B write strobe |
| byteEnB | input | DATA_W/BYTE_SZ | Port B lane write mask |
| inClkEnB | input | 1 | Port B input-stage enable |
| outClkEnB | input | 1 | Port B output-register enable |
| rdDataB | output | DATA_W | Port B read data |

## Verification
The bench instance configures port A as registered on `clk1` (driven in phase with `clk0`), so its read data is due two edges after the request. Port B is unregistered, so its read data is due one edge after the request. Every stimulus is driven 1 time unit after a rising edge. Each port is checked 1 time unit after the edge on which its result is due, and the latency test also samples port A one edge early to confirm it has not yet changed. Asynchronous-clear checks sample mid-cycle, with no edge between the clear and the check. Synchronous-clear checks sample after exactly one edge.

// File: rtl/tdpr_pkg.sv
package tdpr_pkg;

  typedef enum logic [1:0] {
    OUT_UNREG    = 2'd0,
    OUT_REG_CLK0 = 2'd1,
    OUT_REG_CLK1 = 2'd2
  } outMode_e;

  // strobes from a port's control to the datapath
  typedef struct packed {
    logic ceIn;      // effective input-stage enable
    logic ceOut;     // effective output-register enable
    logic holdAclr;  // async clear of holding register (unregistered mode)
    logic holdSclr;  // sync clear of holding register (unregistered mode)
    logic outAclr;   // async clear of output register (registered mode)
    logic outSclr;   // sync clear of output register (registered mode)
  } portStrobe_t;

endpackage

// File: rtl/tdpr_ctrl.sv
module tdpr_ctrl
  import tdpr_pkg::*;
#(
  parameter int       LANES     = 1,
  parameter outMode_e OUT_MODE  = OUT_UNREG,
  parameter bit       ACLR_EN   = 1'b0,
  parameter bit       SCLR_EN   = 1'b0,
  parameter bit       IN_BYPASS = 1'b0,
  parameter bit       OUT_BYPASS = 1'b0
) (
  input  logic             wrEn,
  input  logic [LANES-1:0] byteEn,
  input  logic             inClkEn,
  input  logic             outClkEn,
  input  logic             aclr,
  input  logic             sclr,
  output logic [LANES-1:0] laneWe,
  output portStrobe_t      strobe
);

  localparam bit IS_UNREG = (OUT_MODE == OUT_UNREG);

  logic ceIn;
  logic aclrOn;
  logic sclrOn;

  assign ceIn   = IN_BYPASS ? 1'b1 : inClkEn;
  assign aclrOn = ACLR_EN & aclr;
  assign sclrOn = SCLR_EN & sclr;

  assign laneWe = byteEn & {LANES{wrEn & ceIn}};

  always_comb begin
    strobe.ceIn     = ceIn;
    strobe.ceOut    = OUT_BYPASS ? 1'b1 : outClkEn;
    strobe.holdAclr = IS_UNREG ? aclrOn : 1'b0;
    strobe.holdSclr = IS_UNREG ? sclrOn : 1'b0;
    strobe.outAclr  = IS_UNREG ? 1'b0 : aclrOn;
    strobe.outSclr  = IS_UNREG ? 1'b0 : sclrOn;
  end

endmodule

// File: rtl/tdpr_core.sv
module tdpr_core
  import tdpr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 11,
  parameter int BYTE_SZ = 8
) (
  input  logic                      clk0,
  input  logic [ADDR_W-1:0]         addrA,
  input  logic [DATA_W-1:0]         wrDataA,
  input  logic [DATA_W/BYTE_SZ-1:0] laneWeA,
  input  portStrobe_t               stA,
  input  logic [ADDR_W-1:0]         addrB,
  input  logic [DATA_W-1:0]         wrDataB,
  input  logic [DATA_W/BYTE_SZ-1:0] laneWeB,
  input  portStrobe_t               stB,
  output logic [DATA_W-1:0]         holdA,
  output logic [DATA_W-1:0]         holdB
);

  localparam int LANES = DATA_W / BYTE_SZ;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] storedA, storedB;
  logic [DATA_W-1:0] rdNextA, rdNextB;
  logic              holdAclrA, holdAclrB;

  assign storedA   = mem[addrA];
  assign storedB   = mem[addrB];
  assign holdAclrA = stA.holdAclr;
  assign holdAclrB = stB.holdAclr;

  // B lanes first, A lanes last: A's nonblocking update wins on collisions
  always_ff @(posedge clk0) begin
    for (int l = 0; l < LANES; l++) begin
      if (laneWeB[l]) mem[addrB][l*BYTE_SZ +: BYTE_SZ] <= wrDataB[l*BYTE_SZ +: BYTE_SZ];
    end
    for (int l = 0; l < LANES; l++) begin
      if (laneWeA[l]) mem[addrA][l*BYTE_SZ +: BYTE_SZ] <= wrDataA[l*BYTE_SZ +: BYTE_SZ];
    end
  end

  // same-port read-during-write: written lanes new, masked lanes old
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rdNextA[g*BYTE_SZ +: BYTE_SZ] = laneWeA[g] ? wrDataA[g*BYTE_SZ +: BYTE_SZ]
                                                        : storedA[g*BYTE_SZ +: BYTE_SZ];
      assign rdNextB[g*BYTE_SZ +: BYTE_SZ] = laneWeB[g] ? wrDataB[g*BYTE_SZ +: BYTE_SZ]
                                                        : storedB[g*BYTE_SZ +: BYTE_SZ];
    end
  endgenerate

  always_ff @(posedge clk0 or posedge holdAclrA) begin
    if (holdAclrA)         holdA <= '0;
    else if (stA.holdSclr) holdA <= '0;
    else if (stA.ceIn)     holdA <= rdNextA;
  end

  always_ff @(posedge clk0 or posedge holdAclrB) begin
    if (holdAclrB)         holdB <= '0;
    else if (stB.holdSclr) holdB <= '0;
    else if (stB.ceIn)     holdB <= rdNextB;
  end

  // R4
  rdw_new_a_chk: assert property (@(posedge clk0) disable iff (holdAclrA)
    (laneWeA == '1 && !stA.holdSclr) |=> holdA == $past(wrDataA));

  // R4
  rdw_new_b_chk: assert property (@(posedge clk0) disable iff (holdAclrB)
    (laneWeB == '1 && !stB.holdSclr) |=> holdB == $past(wrDataB));

endmodule

// File: rtl/tdpr_outstage.sv
module tdpr_outstage
  import tdpr_pkg::*;
#(
  parameter int       DATA_W   = 8,
  parameter outMode_e OUT_MODE = OUT_UNREG,
  parameter bit       ACLR_EN  = 1'b0
) (
  input  logic              clk0,
  input  logic              clk1,
  input  portStrobe_t       st,
  input  logic [DATA_W-1:0] hold,
  output logic [DATA_W-1:0] q
);

  generate
    if (OUT_MODE == OUT_UNREG) begin : g_unreg
      logic unusedBits;
      assign unusedBits = ^{clk0, clk1, st};
      assign q = hold;
    end else begin : g_reg
      logic oClk;
      logic clrA;
      assign oClk = (OUT_MODE == OUT_REG_CLK1) ? clk1 : clk0;
      assign clrA = st.outAclr;

      always_ff @(posedge oClk or posedge clrA) begin
        if (clrA)            q <= '0;
        else if (st.outSclr) q <= '0;
        else if (st.ceOut)   q <= hold;
      end

      // R9
      sclr_zero_chk: assert property (@(posedge oClk) disable iff (clrA)
        st.outSclr |=> q == '0);

      // R7
      ce_hold_chk: assert property (@(posedge oClk) disable iff (clrA)
        (!st.ceOut && !st.outSclr) |=> $stable(q));

      if (ACLR_EN) begin : g_aclrChk
        // R8
        aclr_zero_chk: assert property (@(posedge oClk) clrA |-> q == '0);
      end
    end
  endgenerate

endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
  import tdpr_pkg::*;
#(
  parameter int       DATA_W       = 8,
  parameter int       ADDR_W       = 11,
  parameter int       BYTE_SZ      = 8,
  parameter outMode_e OUT_MODE_A   = OUT_REG_CLK0,
  parameter outMode_e OUT_MODE_B   = OUT_REG_CLK0,
  parameter bit       ACLR_EN_A    = 1'b1,
  parameter bit       ACLR_EN_B    = 1'b1,
  parameter bit       SCLR_EN_A    = 1'b0,
  parameter bit       SCLR_EN_B    = 1'b0,
  parameter bit       IN_BYPASS_A  = 1'b0,
  parameter bit       IN_BYPASS_B  = 1'b0,
  parameter bit       OUT_BYPASS_A = 1'b0,
  parameter bit       OUT_BYPASS_B = 1'b0
) (
  input  logic                      clk0,
  input  logic                      clk1,
  input  logic                      aclrA,
  input  logic                      sclrA,
  input  logic [ADDR_W-1:0]         addrA,
  input  logic [DATA_W-1:0]         wrDataA,
  input  logic                      wrEnA,
  input  logic [DATA_W/BYTE_SZ-1:0] byteEnA,
  input  logic                      inClkEnA,
  input  logic                      outClkEnA,
  output logic [DATA_W-1:0]         rdDataA,
  input  logic                      aclrB,
  input  logic                      sclrB,
  input  logic [ADDR_W-1:0]         addrB,
  input  logic [DATA_W-1:0]         wrDataB,
  input  logic                      wrEnB,
  input  logic [DATA_W/BYTE_SZ-1:0] byteEnB,
  input  logic                      inClkEnB,
  input  logic                      outClkEnB,
  output logic [DATA_W-1:0]         rdDataB
);

  localparam int LANES = DATA_W / BYTE_SZ;

  // R1: reject illegal lane sizes and widths at elaboration
  generate
    if (!(BYTE_SZ == 5 || BYTE_SZ == 8 || BYTE_SZ == 9 || BYTE_SZ == 10)) begin : g_badLane
      $error("tdp_ram: BYTE_SZ must be 5, 8, 9 or 10");
    end
    if (DATA_W % BYTE_SZ != 0) begin : g_badWidth
      $error("tdp_ram: DATA_W must be a multiple of BYTE_SZ");
    end
  endgenerate

  logic [LANES-1:0]  laneWeA, laneWeB;
  portStrobe_t       stA, stB;
  logic [DATA_W-1:0] holdA, holdB;

  tdpr_ctrl #(
    .LANES(LANES), .OUT_MODE(OUT_MODE_A), .ACLR_EN(ACLR_EN_A), .SCLR_EN(SCLR_EN_A),
    .IN_BYPASS(IN_BYPASS_A), .OUT_BYPASS(OUT_BYPASS_A)
  ) i_ctrlA (
    .wrEn(wrEnA), .byteEn(byteEnA), .inClkEn(inClkEnA), .outClkEn(outClkEnA),
    .aclr(aclrA), .sclr(sclrA), .laneWe(laneWeA), .strobe(stA)
  );

  tdpr_ctrl #(
    .LANES(LANES), .OUT_MODE(OUT_MODE_B), .ACLR_EN(ACLR_EN_B), .SCLR_EN(SCLR_EN_B),
    .IN_BYPASS(IN_BYPASS_B), .OUT_BYPASS(OUT_BYPASS_B)
  ) i_ctrlB (
    .wrEn(wrEnB), .byteEn(byteEnB), .inClkEn(inClkEnB), .outClkEn(outClkEnB),
    .aclr(aclrB), .sclr(sclrB), .laneWe(laneWeB), .strobe(stB)
  );

  tdpr_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_SZ(BYTE_SZ)) i_core (
    .clk0(clk0),
    .addrA(addrA), .wrDataA(wrDataA), .laneWeA(laneWeA), .stA(stA),
    .addrB(addrB), .wrDataB(wrDataB), .laneWeB(laneWeB), .stB(stB),
    .holdA(holdA), .holdB(holdB)
  );

  tdpr_outstage #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE_A), .ACLR_EN(ACLR_EN_A)) i_outA (
    .clk0(clk0), .clk1(clk1), .st(stA), .hold(holdA), .q(rdDataA)
  );

  tdpr_outstage #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE_B), .ACLR_EN(ACLR_EN_B)) i_outB (
    .clk0(clk0), .clk1(clk1), .st(stB), .hold(holdB), .q(rdDataB)
  );

endmodule

// File: tb/test_tdp_ram.sv
module test_tdp_ram;
  import tdpr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int AW = 4;
  localparam int BS = 5;

  typedef struct packed {
    logic [3:0] addr;
    logic       we;
    logic [1:0] be;
    logic [9:0] d;
    logic [9:0] exp;
  } vec_t;

  // port A vectors; lane0 = bits[4:0], lane1 = bits[9:5]
  localparam vec_t VECS [10] = '{
    '{4'd3,  1'b1, 2'b11, 10'h2A5, 10'h2A5},
    '{4'd5,  1'b1, 2'b11, 10'h13C, 10'h13C},
    '{4'd3,  1'b1, 2'b01, 10'h3FF, 10'h2BF},
    '{4'd3,  1'b1, 2'b10, 10'h000, 10'h01F},
    '{4'd5,  1'b0, 2'b11, 10'h3FF, 10'h13C},
    '{4'd3,  1'b0, 2'b11, 10'h000, 10'h01F},
    '{4'd5,  1'b1, 2'b00, 10'h000, 10'h13C},
    '{4'd15, 1'b1, 2'b11, 10'h3E0, 10'h3E0},
    '{4'd0,  1'b1, 2'b11, 10'h001, 10'h001},
    '{4'd15, 1'b0, 2'b11, 10'h000, 10'h3E0}
  };

  logic clk0 = 1'b0;
  logic clk1;
  logic aclrA, sclrA, wrEnA, inClkEnA, outClkEnA;
  logic aclrB, sclrB, wrEnB, inClkEnB, outClkEnB;
  logic [AW-1:0] addrA, addrB;
  logic [DW-1:0] wrDataA, wrDataB, rdDataA, rdDataB;
  logic [1:0]    byteEnA, byteEnB;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk0 = ~clk0;
  assign clk1 = clk0;

  tdp_ram #(
    .DATA_W(DW), .ADDR_W(AW), .BYTE_SZ(BS),
    .OUT_MODE_A(OUT_REG_CLK1), .OUT_MODE_B(OUT_UNREG),
    .ACLR_EN_A(1'b1), .ACLR_EN_B(1'b0),
    .SCLR_EN_A(1'b1), .SCLR_EN_B(1'b1),
    .IN_BYPASS_A(1'b0), .IN_BYPASS_B(1'b1),
    .OUT_BYPASS_A(1'b0), .OUT_BYPASS_B(1'b1)
  ) i_tdp_ram (
    .clk0(clk0), .clk1(clk1),
    .aclrA(aclrA), .sclrA(sclrA), .addrA(addrA), .wrDataA(wrDataA), .wrEnA(wrEnA),
    .byteEnA(byteEnA), .inClkEnA(inClkEnA), .outClkEnA(outClkEnA), .rdDataA(rdDataA),
    .aclrB(aclrB), .sclrB(sclrB), .addrB(addrB), .wrDataB(wrDataB), .wrEnB(wrEnB),
    .byteEnB(byteEnB), .inClkEnB(inClkEnB), .outClkEnB(outClkEnB), .rdDataB(rdDataB)
  );

  task automatic step();
    @(posedge clk0);
    #1;
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    aclrA = 1'b1; sclrA = 1'b0; wrEnA = 1'b0; inClkEnA = 1'b1; outClkEnA = 1'b1;
    aclrB = 1'b0; sclrB = 1'b1; wrEnB = 1'b0; inClkEnB = 1'b1; outClkEnB = 1'b1;
    addrA = '0; addrB = '0; wrDataA = '0; wrDataB = '0; byteEnA = '0; byteEnB = '0;
    #1;
    check("R8 reset async clear before any edge", rdDataA, 10'h000);
    step();
    step();
    check("R8 reset port A", rdDataA, 10'h000);
    check("R9 sync clear of unregistered port B", rdDataB, 10'h000);
    aclrA = 1'b0; sclrB = 1'b0;

    // vector table: R1 lane mapping, R2 masked writes, R3 latency, R4 read-during-write
    for (int i = 0; i < 10; i++) begin
      addrA = VECS[i].addr; wrEnA = VECS[i].we; byteEnA = VECS[i].be; wrDataA = VECS[i].d;
      step();
      wrEnA = 1'b0;
      step();
      check($sformatf("R1/R2/R4 vector %0d", i), rdDataA, VECS[i].exp);
    end

    // R3: A two edges, B one edge
    addrA = 4'd5; addrB = 4'd3;
    step();
    check("R3 port A not yet updated after one edge", rdDataA, 10'h3E0);
    check("R3 port B updated after one edge", rdDataB, 10'h01F);
    step();
    check("R3 port A updated after two edges", rdDataA, 10'h13C);

    // R6 honoured input enable low: no write, no capture
    inClkEnA = 1'b0; wrEnA = 1'b1; byteEnA = 2'b11; wrDataA = 10'h000; addrA = 4'd5;
    step();
    addrA = 4'd15; wrEnA = 1'b0;
    step();
    step();
    check("R6 port A holds with input enable low", rdDataA, 10'h13C);
    inClkEnA = 1'b1; addrA = 4'd5;
    step();
    step();
    check("R6 port A write blocked", rdDataA, 10'h13C);

    // R6 bypassed input enable on B
    inClkEnB = 1'b0; wrEnB = 1'b1; byteEnB = 2'b11; wrDataB = 10'h155; addrB = 4'd6;
    step();
    check("R6 port B write with bypassed enable", rdDataB, 10'h155);
    wrEnB = 1'b0; addrB = 4'd5;
    step();
    check("R6 port B read with bypassed enable", rdDataB, 10'h13C);

    // R7 output enable hold
    addrA = 4'd15; outClkEnA = 1'b0;
    step();
    step();
    check("R7 output register holds", rdDataA, 10'h13C);
    outClkEnA = 1'b1;
    step();
    check("R7 output register resumes", rdDataA, 10'h3E0);

    // R9 sync clear overrides output enable
    outClkEnA = 1'b0; sclrA = 1'b1;
    step();
    check("R9 sync clear over enable", rdDataA, 10'h000);
    sclrA = 1'b0;
    step();
    check("R9 cleared value held", rdDataA, 10'h000);
    outClkEnA = 1'b1;
    step();
    check("R9 port A after clear", rdDataA, 10'h3E0);

    // R8 async clear mid-cycle
    aclrA = 1'b1;
    #2;
    check("R8 async clear without edge", rdDataA, 10'h000);
    aclrA = 1'b0;
    step();
    step();
    check("R8 port A after async clear", rdDataA, 10'h3E0);
    aclrB = 1'b1;
    #2;
    check("R8 disabled async clear ignored mid-cycle", rdDataB, 10'h13C);
    step();
    check("R8 disabled async clear ignored at edge", rdDataB, 10'h13C);
    aclrB = 1'b0;

    // R5 collision: port A wins
    addrA = 4'd9; addrB = 4'd9; wrEnA = 1'b1; wrEnB = 1'b1;
    byteEnA = 2'b11; byteEnB = 2'b11; wrDataA = 10'h0AA; wrDataB = 10'h155;
    step();
    wrEnA = 1'b0; wrEnB = 1'b0;
    step();
    check("R5 collision read on B", rdDataB, 10'h0AA);
    step();
    check("R5 collision read on A", rdDataA, 10'h0AA);
    addrA = 4'd10; addrB = 4'd10; wrEnA = 1'b1; wrEnB = 1'b1;
    byteEnA = 2'b01; byteEnB = 2'b11; wrDataA = 10'h015; wrDataB = 10'h3FF;
    step();
    wrEnA = 1'b0; wrEnB = 1'b0;
    step();
    check("R5 partial collision lane merge", rdDataB, 10'h3F5);

    // R9 sync clear on unregistered port
    sclrB = 1'b1;
    step();
    check("R9 unregistered sync clear", rdDataB, 10'h000);
    sclrB = 1'b0;
    step();
    check("R9 unregistered port after clear", rdDataB, 10'h3F5);

    summary();
  end

endmodule